// File: doc/BRIEF.md
# Floppy Host Register and Drive-Line Glue

This block sits between a CPU bus and a floppy controller core in a PC-AT style system. It decodes three address lines together with chip select and the read and write strobes. It holds a drive control register and a data rate register. From those two registers it drives the active-low drive select and motor lines, the effective data rate sent to the core, and a dual-purpose output. That output reports spindle speed for dual-speed drives and reduced write current for single-speed drives.

The block also answers the status read that carries the inverted disk-changed line on the top data bit. It gates the core's DMA request and interrupt with the DMA enable bit. It qualifies DMA acknowledge and terminal count in the same way. During a DMA access the address lines and chip select play no part, so such an access can never reach the glue registers. All register writes are taken on the falling edge of the write strobe, sampled by the block clock.

Top module: `fdc_host_glue`

## Requirements
- R1: While reset is high, every select and motor output is high (inactive). After reset, the drive control register holds 0, and the data rate register holds the 250 kb/s code 2'b10. So `rate_sel` reads 2'b10, `rpm_lc` is low, and `drq`, `intr` and `dout_oe` are low.
- R2: A host write (cs_n low, dack_n high) to offset 2 loads the drive control register. Bit 4+i set drives `mtr_n[i]` low, for drive i = 0..3.
- R3: `sel_n[i]` is low only when control bits [1:0] equal i and motor bit 4+i is also set. At most one select is low at a time.
- R4: Control bit 3 gates the outputs: `drq` and `intr` follow `core_drq` and `core_int` when the bit is set, and are low when it is clear.
- R5: `dma_acc` is high only when `dack_n` is low, control bit 3 is set, and `rd_n` or `wr_n` is low. When bit 3 is clear, acknowledge is ignored.
- R6: While `dack_n` is low, a strobe with cs_n low at offset 2 or 7 leaves both registers unchanged.
- R7: A host write to offset 7 loads data bits [1:0] as the rate code: 00 = 500 kb/s, 01 = 300 kb/s, 10 = 250 kb/s, 11 = 1 Mb/s. `rate_sel` outputs that code. The exception is code 01 with `drv_type` low, where `rate_sel` outputs 10.
- R8: With `drv_type` low, `rpm_lc` is high for codes 00 and 11 and low for 01 and 10. With `drv_type` high, `rpm_lc` is high only for code 00.
- R9: A host read at offset 7 drives `dout` = {~dskchg_n, 7'b0} with `dout_oe` high. The disk-changed input passes through two synchronizer flops first.
- R10: `tc_qual` is high only when `tc_in` is high, `dack_n` is low and control bit 3 is set.
- R11: Writes to any other offset leave both registers and all drive outputs unchanged. Data bits [7:2] of a rate write are ignored.
- R12: `dout_oe` is high only during a host read at offset 7. At every other time `dout` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous reset, active high |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| addr | input | 3 | Register offset |
| din | input | 8 | Write data from the CPU |
| dout | output | 8 | Read data to the CPU |
| dout_oe | output | 1 | Read data valid / bus drive enable |
| dack_n | input | 1 | DMA acknowledge, active low |
| tc_in | input | 1 | DMA terminal count |
| core_drq | input | 1 | DMA request from the controller core |
| core_int | input | 1 | Interrupt from the controller core |
| drq | output | 1 | Gated DMA request |
| intr | output | 1 | Gated interrupt |
| tc_qual | output | 1 | Terminal count qualified by acknowledge |
| dma_acc | output | 1 | DMA data access strobe to the core |
| dskchg_n | input | 1 | Disk-changed line from the drive, active low |
| drv_type | input | 1 | High for single-speed drives, low for dual-speed drives |
| sel_n | output | 4 | Drive selects, active low |
| mtr_n | output | 4 | Motor enables, active low |
| rpm_lc | output | 1 | Spindle speed or low write current indication |
| rate_sel | output | 2 | Effective rate code to the core |

## Verification
The assertions assume that the address, chip select, acknowledge and write data are stable at the clock edge that sees the write strobe fall. They also assume the strobe returns high between accesses. The bench changes every bus signal on the falling clock edge only and holds a strobe low for exactly one rising edge, so these conditions always hold. `drv_type` is treated as a static strap between accesses. The bench moves it only while the bus is idle.

// File: rtl/fdc_glue_pkg.sv
package fdc_glue_pkg;
   typedef enum logic [1:0] {
      RATE_500 = 2'b00,
      RATE_300 = 2'b01,
      RATE_250 = 2'b10,
      RATE_1M  = 2'b11
   } rate_e;

   localparam int DRIVES_MAX = 4;
   localparam int RATE_W     = 2;
endpackage

// File: rtl/fdc_host_decode.sv
module fdc_host_decode #(
   parameter int ADDR_W      = 3,
   parameter int DATA_W      = 8,
   parameter int CTRL_OFS    = 2,
   parameter int RATE_OFS    = 7,
   parameter int CHG_BIT     = 7,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              cs_n,
   input  logic              rd_n,
   input  logic              wr_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic              dack_n,
   input  logic              dma_en,
   input  logic              dskchg_n,
   output logic              wr_ctrl,
   output logic              wr_rate,
   output logic              dma_acc,
   output logic [DATA_W-1:0] dout,
   output logic              dout_oe
);
   localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(CTRL_OFS);
   localparam logic [ADDR_W-1:0] RATE_A = ADDR_W'(RATE_OFS);

   if (SYNC_STAGES < 1) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 1");
   end
   if (CHG_BIT >= DATA_W) begin : g_bad_chg
      $error("CHG_BIT outside data width");
   end
   if (CTRL_OFS == RATE_OFS || RATE_OFS >= (1 << ADDR_W) || CTRL_OFS >= (1 << ADDR_W)) begin : g_bad_ofs
      $error("register offsets must differ and fit the address width");
   end

   logic wr_q;
   logic host_cyc;
   logic wr_fall;
   logic chg_seen;

   always_ff @(posedge clk) begin
      if (rst) wr_q <= 1'b1;
      else     wr_q <= wr_n;
   end

   logic [SYNC_STAGES-1:0] chg_pipe;
   if (SYNC_STAGES == 1) begin : g_sync1
      always_ff @(posedge clk) begin
         if (rst) chg_pipe <= 1'b1;
         else     chg_pipe <= dskchg_n;
      end
   end else begin : g_syncn
      always_ff @(posedge clk) begin
         if (rst) chg_pipe <= '1;
         else     chg_pipe <= {chg_pipe[SYNC_STAGES-2:0], dskchg_n};
      end
   end
   assign chg_seen = ~chg_pipe[SYNC_STAGES-1];

   always_comb begin
      host_cyc = !cs_n && dack_n;
      wr_fall  = !wr_n && wr_q;
      wr_ctrl  = host_cyc && wr_fall && (addr == CTRL_A);
      wr_rate  = host_cyc && wr_fall && (addr == RATE_A);
      dma_acc  = !dack_n && dma_en && (!rd_n || !wr_n);
      dout_oe  = host_cyc && !rd_n && (addr == RATE_A);
      dout     = '0;
      if (dout_oe) dout[CHG_BIT] = chg_seen;
   end

   p_oe_host_r12: assert property (@(posedge clk) disable iff (rst)
      dout_oe |-> (!rd_n && !cs_n && dack_n));
   p_dma_blocks_write_r6: assert property (@(posedge clk) disable iff (rst)
      !dack_n |-> (!wr_ctrl && !wr_rate));
endmodule

// File: rtl/fdc_ctrl_regs.sv
module fdc_ctrl_regs
   import fdc_glue_pkg::*;
#(
   parameter int DATA_W     = 8,
   parameter int NUM_DRIVES = 4,
   parameter int SEL_LSB    = 0,
   parameter int DMA_BIT    = 3,
   parameter int MTR_LSB    = 4
) (
   input  logic                  clk,
   input  logic                  rst,
   input  logic                  wr_ctrl,
   input  logic                  wr_rate,
   input  logic [DATA_W-1:0]     din,
   output logic [$clog2(DRIVES_MAX)-1:0] sel,
   output logic [NUM_DRIVES-1:0] mtr_en,
   output logic                  dma_en,
   output rate_e                 rate_code
);
   localparam int SEL_W = $clog2(DRIVES_MAX);

   if (NUM_DRIVES < 1 || NUM_DRIVES > DRIVES_MAX) begin : g_bad_drives
      $error("NUM_DRIVES must be 1..4");
   end
   if (MTR_LSB + NUM_DRIVES > DATA_W || SEL_LSB + SEL_W > DATA_W || DMA_BIT >= DATA_W) begin : g_bad_fields
      $error("control fields exceed data width");
   end

   logic [DATA_W-1:0] ctrl_q;
   rate_e             rate_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         ctrl_q <= '0;
         rate_q <= RATE_250;
      end else begin
         if (wr_ctrl) ctrl_q <= din;
         if (wr_rate) rate_q <= rate_e'(din[RATE_W-1:0]);
      end
   end

   assign sel       = ctrl_q[SEL_LSB +: SEL_W];
   assign mtr_en    = ctrl_q[MTR_LSB +: NUM_DRIVES];
   assign dma_en    = ctrl_q[DMA_BIT];
   assign rate_code = rate_q;

   logic unused_ctrl_bits;
   assign unused_ctrl_bits = ^{ctrl_q, din};

   p_ctrl_hold_r11: assert property (@(posedge clk) disable iff (rst)
      !wr_ctrl |=> $stable(ctrl_q));
   p_rate_hold_r7: assert property (@(posedge clk) disable iff (rst)
      !wr_rate |=> $stable(rate_q));
endmodule

// File: rtl/fdc_drive_if.sv
module fdc_drive_if
   import fdc_glue_pkg::*;
#(
   parameter int NUM_DRIVES = 4
) (
   input  logic                  clk,
   input  logic                  rst,
   input  logic [$clog2(DRIVES_MAX)-1:0] sel,
   input  logic [NUM_DRIVES-1:0] mtr_en,
   input  logic                  dma_en,
   input  rate_e                 rate_code,
   input  logic                  drv_type,
   input  logic                  dack_n,
   input  logic                  tc_in,
   input  logic                  core_drq,
   input  logic                  core_int,
   output logic [NUM_DRIVES-1:0] sel_n,
   output logic [NUM_DRIVES-1:0] mtr_n,
   output logic                  drq,
   output logic                  intr,
   output logic                  tc_qual,
   output logic                  rpm_lc,
   output rate_e                 rate_out
);
   localparam int SEL_W = $clog2(DRIVES_MAX);

   for (genvar i = 0; i < NUM_DRIVES; i++) begin : g_drive
      logic picked;
      assign picked   = (sel == SEL_W'(i)) && mtr_en[i];
      assign sel_n[i] = rst ? 1'b1 : !picked;
      assign mtr_n[i] = rst ? 1'b1 : !mtr_en[i];

      p_sel_has_motor_r3: assert property (@(posedge clk) disable iff (rst)
         !sel_n[i] |-> !mtr_n[i]);
   end

   always_comb begin
      rate_out = rate_code;
      if (!drv_type && rate_code == RATE_300) rate_out = RATE_250;
      if (drv_type) rpm_lc = (rate_code == RATE_500);
      else          rpm_lc = (rate_code == RATE_500) || (rate_code == RATE_1M);
   end

   assign drq     = core_drq && dma_en;
   assign intr    = core_int && dma_en;
   assign tc_qual = tc_in && !dack_n && dma_en;

   p_one_select_r3: assert property (@(posedge clk) disable iff (rst)
      $onehot0(~sel_n));
   p_gate_r4: assert property (@(posedge clk) disable iff (rst)
      !dma_en |-> (!drq && !intr));
   p_tc_needs_dack_r10: assert property (@(posedge clk) disable iff (rst)
      tc_qual |-> !dack_n);
   p_no_300_dual_r7: assert property (@(posedge clk) disable iff (rst)
      !drv_type |-> (rate_out != RATE_300));
   p_lowcur_only_500_r8: assert property (@(posedge clk) disable iff (rst)
      (drv_type && rpm_lc) |-> (rate_out == RATE_500));
endmodule

// File: rtl/fdc_host_glue.sv
module fdc_host_glue
   import fdc_glue_pkg::*;
#(
   parameter int ADDR_W      = 3,
   parameter int DATA_W      = 8,
   parameter int NUM_DRIVES  = 4,
   parameter int CTRL_OFS    = 2,
   parameter int RATE_OFS    = 7,
   parameter int SYNC_STAGES = 2
) (
   input  logic                  clk,
   input  logic                  rst,
   input  logic                  cs_n,
   input  logic                  rd_n,
   input  logic                  wr_n,
   input  logic [ADDR_W-1:0]     addr,
   input  logic [DATA_W-1:0]     din,
   output logic [DATA_W-1:0]     dout,
   output logic                  dout_oe,
   input  logic                  dack_n,
   input  logic                  tc_in,
   input  logic                  core_drq,
   input  logic                  core_int,
   output logic                  drq,
   output logic                  intr,
   output logic                  tc_qual,
   output logic                  dma_acc,
   input  logic                  dskchg_n,
   input  logic                  drv_type,
   output logic [NUM_DRIVES-1:0] sel_n,
   output logic [NUM_DRIVES-1:0] mtr_n,
   output logic                  rpm_lc,
   output logic [RATE_W-1:0]     rate_sel
);
   localparam int SEL_W = $clog2(DRIVES_MAX);

   logic             wr_ctrl, wr_rate, dma_en;
   logic [SEL_W-1:0] sel;
   logic [NUM_DRIVES-1:0] mtr_en;
   rate_e            rate_code, rate_out;

   fdc_host_decode #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CTRL_OFS(CTRL_OFS),
      .RATE_OFS(RATE_OFS), .CHG_BIT(DATA_W-1), .SYNC_STAGES(SYNC_STAGES)
   ) u_decode (
      .clk(clk), .rst(rst), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
      .addr(addr), .dack_n(dack_n), .dma_en(dma_en), .dskchg_n(dskchg_n),
      .wr_ctrl(wr_ctrl), .wr_rate(wr_rate), .dma_acc(dma_acc),
      .dout(dout), .dout_oe(dout_oe)
   );

   fdc_ctrl_regs #(
      .DATA_W(DATA_W), .NUM_DRIVES(NUM_DRIVES)
   ) u_regs (
      .clk(clk), .rst(rst), .wr_ctrl(wr_ctrl), .wr_rate(wr_rate), .din(din),
      .sel(sel), .mtr_en(mtr_en), .dma_en(dma_en), .rate_code(rate_code)
   );

   fdc_drive_if #(
      .NUM_DRIVES(NUM_DRIVES)
   ) u_drive (
      .clk(clk), .rst(rst), .sel(sel), .mtr_en(mtr_en), .dma_en(dma_en),
      .rate_code(rate_code), .drv_type(drv_type), .dack_n(dack_n),
      .tc_in(tc_in), .core_drq(core_drq), .core_int(core_int),
      .sel_n(sel_n), .mtr_n(mtr_n), .drq(drq), .intr(intr),
      .tc_qual(tc_qual), .rpm_lc(rpm_lc), .rate_out(rate_out)
   );

   assign rate_sel = rate_out;
endmodule

// File: tb/fdc_host_glue_test.sv
`timescale 1ns/1ps
module fdc_host_glue_test;
   logic clk = 1'b0;
   logic rst = 1'b1;
   logic cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1, dack_n = 1'b1;
   logic [2:0] addr = '0;
   logic [7:0] din = '0;
   logic tc_in = 1'b0, core_drq = 1'b0, core_int = 1'b0;
   logic dskchg_n = 1'b1, drv_type = 1'b0;
   logic [7:0] dout;
   logic dout_oe, drq, intr, tc_qual, dma_acc, rpm_lc;
   logic [3:0] sel_n, mtr_n;
   logic [1:0] rate_sel;

   int checks = 0;
   int failures = 0;
   int cycles = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   fdc_host_glue uut (
      .clk(clk), .rst(rst), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
      .addr(addr), .din(din), .dout(dout), .dout_oe(dout_oe),
      .dack_n(dack_n), .tc_in(tc_in), .core_drq(core_drq),
      .core_int(core_int), .drq(drq), .intr(intr), .tc_qual(tc_qual),
      .dma_acc(dma_acc), .dskchg_n(dskchg_n), .drv_type(drv_type),
      .sel_n(sel_n), .mtr_n(mtr_n), .rpm_lc(rpm_lc), .rate_sel(rate_sel)
   );

   // vector: [22:20] addr, [19:12] data, [11] drv_type,
   //         [10:7] sel_n, [6:3] mtr_n, [2:1] rate_sel, [0] rpm_lc
   localparam int NV = 13;
   localparam logic [22:0] VEC [NV] = '{
      {3'd2, 8'h10, 1'b0, 4'b1110, 4'b1110, 2'b10, 1'b0},
      {3'd2, 8'h21, 1'b0, 4'b1101, 4'b1101, 2'b10, 1'b0},
      {3'd2, 8'h12, 1'b0, 4'b1111, 4'b1110, 2'b10, 1'b0},
      {3'd2, 8'hF3, 1'b0, 4'b0111, 4'b0000, 2'b10, 1'b0},
      {3'd7, 8'h01, 1'b0, 4'b0111, 4'b0000, 2'b10, 1'b0},
      {3'd7, 8'h01, 1'b1, 4'b0111, 4'b0000, 2'b01, 1'b0},
      {3'd7, 8'h00, 1'b1, 4'b0111, 4'b0000, 2'b00, 1'b1},
      {3'd7, 8'h00, 1'b0, 4'b0111, 4'b0000, 2'b00, 1'b1},
      {3'd7, 8'h03, 1'b1, 4'b0111, 4'b0000, 2'b11, 1'b0},
      {3'd7, 8'h03, 1'b0, 4'b0111, 4'b0000, 2'b11, 1'b1},
      {3'd5, 8'h00, 1'b0, 4'b0111, 4'b0000, 2'b11, 1'b1},
      {3'd7, 8'hFC, 1'b0, 4'b0111, 4'b0000, 2'b00, 1'b1},
      {3'd2, 8'h40, 1'b0, 4'b1111, 4'b1011, 2'b00, 1'b1}
   };

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic bus_write(input logic [2:0] a, input logic [7:0] d, input logic ack_n);
      @(negedge clk);
      addr = a; din = d; dack_n = ack_n; cs_n = 1'b0; wr_n = 1'b0;
      @(negedge clk);
      wr_n = 1'b1; cs_n = 1'b1; dack_n = 1'b1;
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > 100000 && !done) begin
         done = 1'b1;
         failures++;
         $display("FAIL watchdog actual=%0d expected=<100000", cycles);
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      check("R1 sel_n in reset", 32'(sel_n), 32'hF);
      check("R1 mtr_n in reset", 32'(mtr_n), 32'hF);
      rst = 1'b0;
      @(negedge clk);
      check("R1 rate after reset", 32'(rate_sel), 32'h2);
      check("R1 rpm_lc after reset", 32'(rpm_lc), 32'h0);
      core_drq = 1'b1; core_int = 1'b1;
      @(negedge clk);
      check("R1 drq after reset", 32'(drq), 32'h0);
      check("R4 intr gated", 32'(intr), 32'h0);
      check("R12 oe idle", 32'(dout_oe), 32'h0);

      // vector table: R2 R3 R7 R8 R11
      for (int k = 0; k < NV; k++) begin
         drv_type = VEC[k][11];
         bus_write(VEC[k][22:20], VEC[k][19:12], 1'b1);
         check("R2 R3 sel_n", 32'(sel_n), 32'(VEC[k][10:7]));
         check("R2 R11 mtr_n", 32'(mtr_n), 32'(VEC[k][6:3]));
         check("R7 rate_sel", 32'(rate_sel), 32'(VEC[k][2:1]));
         check("R8 rpm_lc", 32'(rpm_lc), 32'(VEC[k][0]));
      end

      // R4: enable DMA/interrupt gating
      bus_write(3'd2, 8'h08, 1'b1);
      check("R4 drq passes", 32'(drq), 32'h1);
      check("R4 intr passes", 32'(intr), 32'h1);
      core_int = 1'b0;
      #1 check("R4 intr follows core", 32'(intr), 32'h0);

      // R6: write with acknowledge low must not hit the registers
      bus_write(3'd2, 8'hF0, 1'b0);
      check("R6 mtr_n unchanged", 32'(mtr_n), 32'hF);
      bus_write(3'd7, 8'h01, 1'b0);
      check("R6 rate unchanged", 32'(rate_sel), 32'h0);

      // R5 / R10 with DMA enabled
      @(negedge clk);
      dack_n = 1'b0; rd_n = 1'b0; tc_in = 1'b1;
      #1 check("R5 dma_acc active", 32'(dma_acc), 32'h1);
      check("R10 tc qualified", 32'(tc_qual), 32'h1);
      check("R12 no oe in dma", 32'(dout_oe), 32'h0);
      @(negedge clk);
      rd_n = 1'b1;
      #1 check("R5 no strobe", 32'(dma_acc), 32'h0);
      dack_n = 1'b1;
      #1 check("R10 tc without dack", 32'(tc_qual), 32'h0);

      // R5 / R10 with DMA disabled
      bus_write(3'd2, 8'h00, 1'b1);
      @(negedge clk);
      dack_n = 1'b0; rd_n = 1'b0;
      #1 check("R5 dack ignored", 32'(dma_acc), 32'h0);
      check("R10 tc ignored", 32'(tc_qual), 32'h0);
      check("R4 drq blocked", 32'(drq), 32'h0);
      @(negedge clk);
      dack_n = 1'b1; rd_n = 1'b1; tc_in = 1'b0;

      // R9: disk-changed read back
      dskchg_n = 1'b0;
      repeat (3) @(negedge clk);
      addr = 3'd7; cs_n = 1'b0; rd_n = 1'b0;
      #1 check("R9 dout changed", 32'(dout), 32'h80);
      check("R9 oe", 32'(dout_oe), 32'h1);
      @(negedge clk);
      rd_n = 1'b1; cs_n = 1'b1;
      dskchg_n = 1'b1;
      repeat (3) @(negedge clk);
      addr = 3'd7; cs_n = 1'b0; rd_n = 1'b0;
      #1 check("R9 dout clear", 32'(dout), 32'h00);
      @(negedge clk);
      addr = 3'd2;
      #1 check("R12 no oe at offset 2", 32'(dout_oe), 32'h0);
      check("R12 dout zero", 32'(dout), 32'h0);
      rd_n = 1'b1; cs_n = 1'b1;

      // R1: reset mid-run forces drive lines inactive
      bus_write(3'd2, 8'h11, 1'b1);
      check("R3 drive1 not selected without motor1", 32'(sel_n), 32'hF);
      bus_write(3'd2, 8'h10, 1'b1);
      check("R3 drive0 selected", 32'(sel_n), 32'hE);
      @(negedge clk);
      rst = 1'b1;
      #1 check("R1 sel_n forced high", 32'(sel_n), 32'hF);
      check("R1 mtr_n forced high", 32'(mtr_n), 32'hF);
      @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      check("R1 rate restored", 32'(rate_sel), 32'h2);
      check("R1 motors off", 32'(mtr_n), 32'hF);

      if (!done) begin
         done = 1'b1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule